// File: doc/BRIEF.md
# Masked Two-Stage Block Write Buffer

This block sits between a host port and a memory array and holds two cascaded block buffers. Each buffer holds one block of eight 16-bit words together with a per-byte transfer mask, where a set mask bit means "do not write this byte". The host fills the first stage one word at a time with byte enables, or all at once from a cache row. The array side issues transfer commands. A command either promotes the first stage into the second and writes it, or writes the second stage again exactly as it stands. The same held block can therefore be stored to many array blocks.

Each transfer produces, one cycle later, a strobe together with the block data, the target block address and a 16-bit write-enable vector (one bit per byte, 1 = write). The mask bits follow fixed rules. Host writes clear them. A promotion sets all first-stage bits, unless a configuration input asks that they be kept. A reuse touches nothing. A separate byte-mask register, loaded from the host data lines, can stand in for the buffer masks on a transfer. A host write or row load in the same cycle as a promotion is merged into the promoted block.

Top module: `mwb_top`

## Requirements
- R1: After reset `arr_stb` is 0, both stages hold all-zero data and every mask bit of both stages is set, so a reuse command issued right after reset yields data 0 and `arr_we` 0.
- R2: A host word write (`hw_en`) at word address `hw_addr` writes byte lane L of `hw_data` (lane 0 = bits 7:0, lane 1 = bits 15:8) only where `hw_be[L]` is 1, and clears only those mask bits. Mask and write-enable bit index is L*8 + word.
- R3: A row load (`row_ld`) replaces the whole first-stage block with `row_data` (word w in bits w*16+15:w*16) and clears all first-stage mask bits, whatever `hw_be` is.
- R4: A promote command (`xf_kind` 0) copies first-stage data and mask into the second stage and outputs that data with `arr_we` = inverted mask. It then sets every first-stage mask bit when `keep_s1_mask` is 0, so an immediate second promote yields `arr_we` 0.
- R5: A reuse command (`xf_kind` 1) outputs the second-stage data with `arr_we` = inverted second-stage mask and leaves the second stage unchanged, so repeated reuses to different block addresses give identical data and enables.
- R6: A host word write or row load in the same cycle as a promote is merged into the first stage before the copy and appears in that transfer.
- R7: `bm_ld` loads the byte-mask register from `hw_data` (1 = write enabled). Kinds 2 and 3 behave as kinds 0 and 1, except that `arr_we` equals the byte-mask register. Kind 2 still copies the first-stage mask into the second stage and sets the first-stage mask.
- R8: With `keep_s1_mask` at 1, a promote leaves the first-stage mask as it was, so a second promote repeats the same `arr_we`.
- R9: `arr_stb` is 1 exactly in the cycle after each cycle with `xf_en` 1, `arr_blk` carries that command's `xf_blk`, and whenever `arr_stb` is 0 both `arr_data` and `arr_we` are 0.
- R10: When a row load and a host word write occur in the same cycle, the word write is applied on top of the loaded row.
- R11: A transfer in the same cycle as `bm_ld` uses the byte-mask register value from before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Host single-word write |
| hw_addr | input | 3 | Word address within the block |
| hw_be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| hw_data | input | 16 | Host write data, also byte-mask load value |
| row_ld | input | 1 | Load whole block into first stage |
| row_data | input | 128 | Block from cache row |
| bm_ld | input | 1 | Load byte-mask register from hw_data |
| keep_s1_mask | input | 1 | 1 = keep first-stage mask after promote |
| xf_en | input | 1 | Transfer command valid |
| xf_kind | input | 2 | 0 promote, 1 reuse, 2 promote with byte mask, 3 reuse with byte mask |
| xf_blk | input | 10 | Array block address for the transfer |
| arr_stb | output | 1 | Transfer result valid |
| arr_blk | output | 10 | Array block address |
| arr_data | output | 128 | Block data to the array |
| arr_we | output | 16 | Per-byte write enable, index lane*8+word |

## Verification
The hardest case to reach is the difference between the two mask stages after a byte-mask promote. The output then shows only the register value, so the copied buffer mask stays hidden until a later plain reuse exposes the second stage and a plain promote exposes the re-set first stage. The stimulus chains kind 2, kind 1, kind 3 and kind 0 back to back for this reason. It also lines up same-cycle row loads, word writes and byte-mask loads against promotes, so that the merge order and the old-register rule show at the outputs.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
    typedef enum logic [1:0] {
        XK_PROMOTE    = 2'd0,
        XK_REUSE      = 2'd1,
        XK_PROMOTE_BM = 2'd2,
        XK_REUSE_BM   = 2'd3
    } xfer_kind_e;

    function automatic logic kind_promotes(input xfer_kind_e k);
        return (k == XK_PROMOTE) || (k == XK_PROMOTE_BM);
    endfunction

    function automatic logic kind_uses_bm(input xfer_kind_e k);
        return (k == XK_PROMOTE_BM) || (k == XK_REUSE_BM);
    endfunction
endpackage

// File: rtl/mwb_stage1.sv
module mwb_stage1 #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 16,
    localparam int LANES  = WORD_W / 8,
    localparam int BLK_W  = WORDS * WORD_W,
    localparam int MASK_W = WORDS * LANES,
    localparam int WA_W   = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WA_W-1:0]   wr_addr,
    input  logic [LANES-1:0]  wr_be,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ld_en,
    input  logic [BLK_W-1:0]  ld_data,
    input  logic              promote,
    input  logic              keep_mask,
    output logic [BLK_W-1:0]  mrg_data,
    output logic [MASK_W-1:0] mrg_mask
);
    typedef struct packed {
        logic [BLK_W-1:0]  data;
        logic [MASK_W-1:0] mask;
    } s1_t;

    s1_t st_q, st_d, mrg;

    // Merge order: row load first, word write on top, then the promote rule.
    always_comb begin
        mrg = st_q;
        if (ld_en) begin
            mrg.data = ld_data;
            mrg.mask = '0;
        end
        if (wr_en) begin
            for (int ln = 0; ln < LANES; ln++) begin
                if (wr_be[ln]) begin
                    mrg.data[int'(wr_addr) * WORD_W + ln * 8 +: 8] = wr_data[ln * 8 +: 8];
                    mrg.mask[ln * WORDS + int'(wr_addr)] = 1'b0;
                end
            end
        end
        st_d = mrg;
        if (promote && !keep_mask) begin
            st_d.mask = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mrg_data = mrg.data;
    assign mrg_mask = mrg.mask;

    p_load_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !promote) |=> (st_q.mask == '0));

    p_write_never_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ld_en && !promote) |=> ((st_q.mask & ~$past(st_q.mask)) == '0));

    p_promote_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (promote && !keep_mask) |=> (st_q.mask == '1));

    p_keep_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (promote && keep_mask && !ld_en && !wr_en) |=> $stable(st_q.mask));
endmodule

// File: rtl/mwb_stage2.sv
module mwb_stage2 #(
    parameter int BLK_W  = 128,
    parameter int MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              promote,
    input  logic [BLK_W-1:0]  in_data,
    input  logic [MASK_W-1:0] in_mask,
    output logic [BLK_W-1:0]  q_data,
    output logic [MASK_W-1:0] q_mask
);
    typedef struct packed {
        logic [BLK_W-1:0]  data;
        logic [MASK_W-1:0] mask;
    } s2_t;

    s2_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (promote) begin
            st_d.data = in_data;
            st_d.mask = in_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_data = st_q.data;
    assign q_mask = st_q.mask;

    p_reuse_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !promote |=> $stable(st_q));

    p_promote_takes_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        promote |=> (st_q.mask == $past(in_mask)));
endmodule

// File: rtl/mwb_drive.sv
module mwb_drive #(
    parameter int BLK_W  = 128,
    parameter int MASK_W = 16,
    parameter int BLKA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_en,
    input  logic              promote,
    input  logic              use_bm,
    input  logic [BLKA_W-1:0] xfer_blk,
    input  logic [BLK_W-1:0]  new_data,
    input  logic [MASK_W-1:0] new_mask,
    input  logic [BLK_W-1:0]  old_data,
    input  logic [MASK_W-1:0] old_mask,
    input  logic              bm_ld,
    input  logic [MASK_W-1:0] bm_in,
    output logic              o_stb,
    output logic [BLKA_W-1:0] o_blk,
    output logic [BLK_W-1:0]  o_data,
    output logic [MASK_W-1:0] o_we
);
    typedef struct packed {
        logic              stb;
        logic [BLKA_W-1:0] blk;
        logic [BLK_W-1:0]  data;
        logic [MASK_W-1:0] we;
    } out_t;

    out_t              o_q, o_d;
    logic [MASK_W-1:0] bm_q, bm_d;

    always_comb begin
        o_d  = '0;
        bm_d = bm_ld ? bm_in : bm_q;
        if (xfer_en) begin
            o_d.stb  = 1'b1;
            o_d.blk  = xfer_blk;
            o_d.data = promote ? new_data : old_data;
            o_d.we   = use_bm ? bm_q : ~(promote ? new_mask : old_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q  <= '0;
            bm_q <= '0;
        end else begin
            o_q  <= o_d;
            bm_q <= bm_d;
        end
    end

    assign o_stb  = o_q.stb;
    assign o_blk  = o_q.blk;
    assign o_data = o_q.data;
    assign o_we   = o_q.we;

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !o_q.stb |-> ((o_q.we == '0) && (o_q.data == '0)));

    p_stb_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en |=> o_q.stb);

    p_bm_prior_value_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_en && use_bm) |=> (o_q.we == $past(bm_q)));
endmodule

// File: rtl/mwb_top.sv
module mwb_top #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 16,
    parameter int BLKA_W = 10,
    localparam int LANES  = WORD_W / 8,
    localparam int BLK_W  = WORDS * WORD_W,
    localparam int MASK_W = WORDS * LANES,
    localparam int WA_W   = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic [WA_W-1:0]   hw_addr,
    input  logic [LANES-1:0]  hw_be,
    input  logic [WORD_W-1:0] hw_data,
    input  logic              row_ld,
    input  logic [BLK_W-1:0]  row_data,
    input  logic              bm_ld,
    input  logic              keep_s1_mask,
    input  logic              xf_en,
    input  logic [1:0]        xf_kind,
    input  logic [BLKA_W-1:0] xf_blk,
    output logic              arr_stb,
    output logic [BLKA_W-1:0] arr_blk,
    output logic [BLK_W-1:0]  arr_data,
    output logic [MASK_W-1:0] arr_we
);
    import mwb_pkg::*;

    xfer_kind_e        kind;
    logic              do_promote;
    logic              do_bm;
    logic [BLK_W-1:0]  s1_mrg_data;
    logic [MASK_W-1:0] s1_mrg_mask;
    logic [BLK_W-1:0]  s2_data;
    logic [MASK_W-1:0] s2_mask;
    logic [MASK_W-1:0] bm_src;

    assign kind       = xfer_kind_e'(xf_kind);
    assign do_promote = xf_en && kind_promotes(kind);
    assign do_bm      = kind_uses_bm(kind);
    assign bm_src     = MASK_W'(hw_data);

    mwb_stage1 #(.WORDS(WORDS), .WORD_W(WORD_W)) u_stage1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (hw_en),
        .wr_addr   (hw_addr),
        .wr_be     (hw_be),
        .wr_data   (hw_data),
        .ld_en     (row_ld),
        .ld_data   (row_data),
        .promote   (do_promote),
        .keep_mask (keep_s1_mask),
        .mrg_data  (s1_mrg_data),
        .mrg_mask  (s1_mrg_mask)
    );

    mwb_stage2 #(.BLK_W(BLK_W), .MASK_W(MASK_W)) u_stage2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .promote (do_promote),
        .in_data (s1_mrg_data),
        .in_mask (s1_mrg_mask),
        .q_data  (s2_data),
        .q_mask  (s2_mask)
    );

    mwb_drive #(.BLK_W(BLK_W), .MASK_W(MASK_W), .BLKA_W(BLKA_W)) u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer_en  (xf_en),
        .promote  (do_promote),
        .use_bm   (do_bm),
        .xfer_blk (xf_blk),
        .new_data (s1_mrg_data),
        .new_mask (s1_mrg_mask),
        .old_data (s2_data),
        .old_mask (s2_mask),
        .bm_ld    (bm_ld),
        .bm_in    (bm_src),
        .o_stb    (arr_stb),
        .o_blk    (arr_blk),
        .o_data   (arr_data),
        .o_we     (arr_we)
    );

    p_reuse_repeats_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_stb && xf_en && (kind == XK_REUSE) && $past(xf_en && (kind == XK_REUSE)))
        |=> (arr_data == $past(arr_data)) && (arr_we == $past(arr_we)));
endmodule

// File: tb/mwb_top_tb_top.sv
module mwb_top_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hw_en = 1'b0;
    logic [2:0]   hw_addr = '0;
    logic [1:0]   hw_be = '0;
    logic [15:0]  hw_data = '0;
    logic         row_ld = 1'b0;
    logic [127:0] row_data = '0;
    logic         bm_ld = 1'b0;
    logic         keep_s1_mask = 1'b0;
    logic         xf_en = 1'b0;
    logic [1:0]   xf_kind = '0;
    logic [9:0]   xf_blk = '0;
    logic         arr_stb;
    logic [9:0]   arr_blk;
    logic [127:0] arr_data;
    logic [15:0]  arr_we;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench-side reference state
    logic [127:0] m1d = '0, m2d = '0;
    logic [15:0]  m1m = '1, m2m = '1, mbm = '0;

    logic [127:0] q_data[$];
    logic [15:0]  q_we[$];
    logic [9:0]   q_blk[$];
    string        q_tag[$];

    always #10 clk = ~clk;

    mwb_top dut_i (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_addr(hw_addr), .hw_be(hw_be),
        .hw_data(hw_data), .row_ld(row_ld), .row_data(row_data), .bm_ld(bm_ld),
        .keep_s1_mask(keep_s1_mask), .xf_en(xf_en), .xf_kind(xf_kind), .xf_blk(xf_blk),
        .arr_stb(arr_stb), .arr_blk(arr_blk), .arr_data(arr_data), .arr_we(arr_we)
    );

    task automatic check128(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: called at a falling edge; applies one cycle of stimulus and pushes expectations.
    task automatic cyc(input logic wr, input logic [2:0] a, input logic [1:0] be,
                       input logic [15:0] d, input logic ld, input logic [127:0] ldd,
                       input logic x, input logic [1:0] k, input logic [9:0] blk,
                       input logic bml, input string tag);
        logic [127:0] n1d;
        logic [15:0]  n1m;
        logic [127:0] sd;
        logic [15:0]  sm;
        logic         prom;
        hw_en = wr; hw_addr = a; hw_be = be; hw_data = d;
        row_ld = ld; row_data = ldd; xf_en = x; xf_kind = k; xf_blk = blk; bm_ld = bml;
        n1d = m1d; n1m = m1m;
        if (ld) begin n1d = ldd; n1m = '0; end
        if (wr) begin
            for (int ln = 0; ln < 2; ln++) begin
                if (be[ln]) begin
                    n1d[int'(a) * 16 + ln * 8 +: 8] = d[ln * 8 +: 8];
                    n1m[ln * 8 + int'(a)] = 1'b0;
                end
            end
        end
        if (x) begin
            prom = (k == 2'd0) || (k == 2'd2);
            sd = prom ? n1d : m2d;
            sm = prom ? n1m : m2m;
            q_data.push_back(sd);
            q_we.push_back(k[1] ? mbm : ~sm);
            q_blk.push_back(blk);
            q_tag.push_back(tag);
            if (prom) begin
                m2d = n1d; m2m = n1m;
                if (!keep_s1_mask) n1m = '1;
            end
        end
        if (bml) mbm = d;
        m1d = n1d; m1m = n1m;
        @(posedge clk);
        @(negedge clk);
        hw_en = 1'b0; row_ld = 1'b0; xf_en = 1'b0; bm_ld = 1'b0;
    endtask

    task automatic idle();
        cyc(1'b0, 3'd0, 2'b00, 16'h0, 1'b0, '0, 1'b0, 2'd0, 10'd0, 1'b0, "idle");
    endtask

    // Monitor: pops expected results as strobes appear.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (arr_stb) begin
                if (q_data.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R9 unexpected strobe actual=1 expected=0");
                end else begin
                    string t;
                    logic [127:0] ed;
                    logic [15:0]  ew;
                    logic [9:0]   eb;
                    t = q_tag.pop_front(); ed = q_data.pop_front();
                    ew = q_we.pop_front(); eb = q_blk.pop_front();
                    check128({t, " data"}, arr_data, ed);
                    check128({t, " we"}, {112'd0, arr_we}, {112'd0, ew});
                    check128({t, " R9 blk"}, {118'd0, arr_blk}, {118'd0, eb});
                end
            end else begin
                check128("R9 idle we", {112'd0, arr_we}, 128'd0);
                check128("R9 idle data", arr_data, 128'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] row_a;
        logic [127:0] row_b;
        row_a = 128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100;
        row_b = 128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100;
        repeat (3) @(negedge clk);
        check128("R1 reset stb", {127'd0, arr_stb}, 128'd0);
        check128("R1 reset we", {112'd0, arr_we}, 128'd0);
        rst_n = 1'b1;
        // R1: reuse right after reset shows zero data, all bytes masked
        cyc(0, 0, 2'b00, 0, 0, '0, 1, 2'd1, 10'd4, 0, "R1 reuse after reset");
        // R2: partial byte writes, then promote (R4)
        cyc(1, 3'd3, 2'b01, 16'hA1B2, 0, '0, 0, 0, 0, 0, "R2");
        cyc(1, 3'd5, 2'b10, 16'h1234, 0, '0, 0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, '0, 1, 2'd0, 10'd7, 0, "R2 R4 promote");
        cyc(0, 0, 0, 0, 0, '0, 1, 2'd0, 10'd8, 0, "R4 second promote");
        // R5: reuse twice to different blocks
        cyc(0, 0, 0, 0, 0, '0, 1, 2'd1, 10'd100, 0, "R5 reuse a");
        cyc(0, 0, 0, 0, 0, '0, 1, 2'd1, 10'd513, 0, "R5 reuse b");
        // R3: row load with no byte enables clears all mask bits
        cyc(0, 0, 2'b00, 0, 1, row_a, 0, 0, 0, 0, "R3");
        cyc(0, 0, 0, 0, 0, '0, 1, 2'd0, 10'd9, 0, "R3 promote after load");
        // R6: same-cycle word write and promote, then same-cycle load and promote
        cyc(1, 3'd0, 2'b11, 16'hCAFE, 0, '0, 1, 2'd0, 10'd10, 0, "R6 write merge");
        cyc(0, 0, 0, 0, 1, row_b, 1, 2'd0, 10'd11, 0, "R6 load merge");
        // R10: load and word write together, word wins
        cyc(1, 3'd7, 2'b10, 16'h5A00, 1, row_a, 0, 0, 0, 0, "R10");
        cyc(0, 0, 0, 0, 0, '0, 1, 2'd0, 10'd12, 0, "R10 promote");
        // R8: keep first-stage mask across promotes
        keep_s1_mask = 1'b1;
        cyc(1, 3'd2, 2'b01, 16'h0077, 0, '0, 0, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, '0, 1, 2'd0, 10'd13, 0, "R8 promote a");
        cyc(0, 0, 0, 0, 0, '0, 1, 2'd0, 10'd14, 0, "R8 promote b");
        keep_s1_mask = 1'b0;
        cyc(0, 0, 0, 0, 0, '0, 1, 2'd0, 10'd15, 0, "R4 promote clears kept");
        // R7: byte-mask register path
        cyc(0, 0, 0, 16'h00F0, 0, '0, 0, 0, 0, 1, "R7 bm load");
        cyc(1, 3'd1, 2'b11, 16'hBEEF, 0, '0, 0, 0, 0, 0, "R7");
        cyc(0, 0, 0, 0, 0, '0, 1, 2'd2, 10'd20, 0, "R7 promote bm");
        cyc(0, 0, 0, 0, 0, '0, 1, 2'd1, 10'd21, 0, "R7 reuse shows copied mask");
        cyc(0, 0, 0, 0, 0, '0, 1, 2'd3, 10'd22, 0, "R7 reuse bm");
        cyc(0, 0, 0, 0, 0, '0, 1, 2'd0, 10'd23, 0, "R7 stage1 set after bm promote");
        // R11: bm load in same cycle as bm transfer uses old value
        cyc(0, 0, 0, 16'h8001, 0, '0, 1, 2'd3, 10'd24, 1, "R11 old bm");
        cyc(0, 0, 0, 0, 0, '0, 1, 2'd3, 10'd25, 0, "R11 new bm");
        idle();
        idle();
        checks++;
        if (q_data.size() != 0) begin
            errors++;
            $display("FAIL R9 pending results actual=%0d expected=0", q_data.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule